// File: doc/BRIEF.md
# I2C serial EEPROM slave controller

This block is the bus-facing half of a serial EEPROM. It watches an open-drain two-wire bus (SCL and SDA) using an oversampling system clock. It answers only when the select byte carries one of its two device type codes and the three chip-enable pins match. It turns the transfer into accesses on a synchronous byte memory port that sits outside the block. Writes can be single bytes or page bursts with in-page wrap. Reads can be at the current address, at a random address set by a dummy write, or sequential until the master declines a byte.

A write-control input blocks data bytes without disturbing addressing. After a write, a programmable busy window models the internal programming time. While that window runs, the block stays silent on its select byte, so a master can poll for completion. A second device type code opens a 64-byte identification page that lives inside the block. That page can be locked permanently, until the next reset. A one-byte probe write reports the lock state through its acknowledge.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte is taken MSB first. Bits 7:4 must be 1010 (main array) or 1011 (identification page), bits 3:1 must equal `chip_en[2:0]`, and bit 0 is the direction (1 = read). On any mismatch the byte gets no acknowledge, and the block drives nothing until the next Start.
- R2: A write sends the select byte, then the address high byte, then the address low byte, and each is acknowledged. The low ADDR_W bits of the 16-bit address select the byte. Each accepted data byte is stored at the current address.
- R3: During a write burst the low PAGE_W (6) address bits step by one and wrap inside the current page. The upper bits stay unchanged.
- R4: While `wc` is high, select and address bytes are still acknowledged, but data bytes get no acknowledge, nothing is stored and no busy window starts. Reads work at either `wc` level.
- R5: A Stop that ends a write in which at least one data byte was accepted starts a busy window of WRITE_CYCLES clocks. During that window every select byte gets no acknowledge. A Stop after a write with no accepted data byte starts no window.
- R6: A read returns the byte at the current address and then advances the address by one. A read select straight after Start continues from the last address. A dummy write (select plus two address bytes, then repeated Start) sets the address for a random read.
- R7: When the master acknowledges a read byte, the next byte follows. A read past the top address continues at address 0. A NoAck releases the bus until Start or Stop.
- R8: The block changes its SDA drive only while SCL is low. A Start (SDA falling with SCL high) restarts select decoding at any bit position. A Stop (SDA rising with SCL high) ends the transfer.
- R9: With type 1011 the low 6 address bits select an identification byte. Writes and sequential reads wrap within those 64 bytes. An accepted identification data byte is stored at once, even if a repeated Start then ends the transfer.
- R10: An identification write whose address bit 10 is 1 and whose data byte is accepted locks the page at the following Stop. Once locked, identification data bytes get no acknowledge and the page is unchanged. So the probe "select, two address bytes, one data byte" acknowledges exactly when the page is unlocked. Reset clears the lock.
- R11: Read data leaves MSB first. The block releases SDA during the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| chip_en | input | 3 | Address pins compared with select bits 3:1 |
| wc | input | 1 | Write control, high blocks data bytes |
| mem_addr | output | ADDR_W | Memory port address |
| mem_we | output | 1 | Memory port write strobe |
| mem_wdata | output | 8 | Memory port write data |
| mem_rdata | input | 8 | Memory port read data, one clock after address |

## Verification
Two functions meet in a single clock: the last count of the busy window after a write, and the acknowledge decision on a polling select byte. The bench repeats a byte write followed by a poll. The pause after Stop moves in small steps across the end of the window, so the poll's acknowledge slot lands before, on and after that end. The outcome is judged as a step function. Early polls must go unanswered and late polls must be acknowledged. Once any poll has been acknowledged, no later, longer pause may be refused. Each written byte is read back afterwards to show that the write finished.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_MAIN = 4'b1010;
  localparam logic [3:0] DEV_IDPG = 4'b1011;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_e,
  output logic stop_e
);
  logic [1:0] scl_m, sda_m;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_p <= scl_m[1];
      sda_p <= sda_m[1];
    end
  end

  assign scl_s    = scl_m[1];
  assign sda_s    = sda_m[1];
  assign scl_rise = ~scl_p & scl_s;
  assign scl_fall = scl_p & ~scl_s;
  assign start_e  = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_e   = scl_p & scl_s & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
  parameter int CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (kick)        left <= LOADV;
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R5: the busy window opens only after a write-ending Stop
  a_r5_busy_from_kick: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(kick));
endmodule

// File: rtl/id_page_store.sv
module id_page_store #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] raddr,
  output logic [7:0]        rdata,
  input  logic              lock_set,
  output logic              locked
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0] cells [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst)           locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  // R10: a locked page never takes a write
  a_r10_locked_refuses: assert property (@(posedge clk) disable iff (rst)
    we |-> !locked);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 1250000,
  parameter int LOCK_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_en,
  input  logic              wc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_e, stop_e;
  logic busy, kick, locked, lock_set;

  phase_t            ph;
  logic [3:0]        bcnt;
  logic [7:0]        sh, ahi, txb, id_rdata, id_wd_q, rd_byte;
  logic              id_sel, rw, acked, oe, wrote, lock_cmd, lock_pend;
  logic [ADDR_W-1:0] ptr, ptr_pinc, mem_addr_q;
  logic [PAGE_W-1:0] idp, id_wa_q;
  logic              mem_we_q, id_we_q;
  logic [7:0]        mem_wd_q;
  logic [15:0]       abus;
  logic              sel_hit, data_ok;

  i2c_line_sampler u_lines (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_e(start_e), .stop_e(stop_e)
  );

  eeprom_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy)
  );

  id_page_store #(.PAGE_W(PAGE_W)) u_idpg (
    .clk(clk), .rst(rst), .we(id_we_q), .waddr(id_wa_q), .wdata(id_wd_q),
    .raddr(idp), .rdata(id_rdata), .lock_set(lock_set), .locked(locked)
  );

  assign abus     = {ahi, sh};
  assign ptr_pinc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
  assign sel_hit  = ((sh[7:4] == DEV_MAIN) || (sh[7:4] == DEV_IDPG)) &&
                    (sh[3:1] == chip_en) && !busy;
  assign data_ok  = !wc && !(id_sel && locked);
  assign rd_byte  = id_sel ? id_rdata : mem_rdata;

  generate
    if (ADDR_W < 16) begin : g_spare
      logic unused_addr_bits;
      assign unused_addr_bits = ^abus[15:ADDR_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      bcnt       <= '0;
      sh         <= '0;
      ahi        <= '0;
      txb        <= '0;
      id_sel     <= 1'b0;
      rw         <= 1'b0;
      acked      <= 1'b0;
      oe         <= 1'b0;
      wrote      <= 1'b0;
      lock_cmd   <= 1'b0;
      lock_pend  <= 1'b0;
      lock_set   <= 1'b0;
      kick       <= 1'b0;
      ptr        <= '0;
      idp        <= '0;
      mem_addr_q <= '0;
      mem_we_q   <= 1'b0;
      mem_wd_q   <= '0;
      id_we_q    <= 1'b0;
      id_wa_q    <= '0;
      id_wd_q    <= '0;
    end else begin
      mem_we_q   <= 1'b0;
      id_we_q    <= 1'b0;
      lock_set   <= 1'b0;
      kick       <= 1'b0;
      mem_addr_q <= ptr;
      if (start_e) begin
        ph        <= PH_DEV;
        bcnt      <= '0;
        oe        <= 1'b0;
        wrote     <= 1'b0;
        lock_pend <= 1'b0;
      end else if (stop_e) begin
        ph        <= PH_IDLE;
        oe        <= 1'b0;
        kick      <= wrote;
        lock_set  <= lock_pend;
        wrote     <= 1'b0;
        lock_pend <= 1'b0;
      end else if (ph != PH_IDLE && ph != PH_SKIP) begin
        if (scl_rise) begin
          if (bcnt < 4'd8) sh <= {sh[6:0], sda_s};
          if (bcnt == 4'd8 && ph == PH_RDAT) begin
            if (id_sel) idp <= idp + 1'b1;
            else        ptr <= ptr + 1'b1;
            if (sda_s)  ph  <= PH_SKIP;
          end
          bcnt <= bcnt + 4'd1;
        end else if (scl_fall) begin
          if (bcnt == 4'd8) begin
            case (ph)
              PH_DEV: begin
                oe     <= sel_hit;
                acked  <= sel_hit;
                id_sel <= sh[4];
                rw     <= sh[0];
              end
              PH_AHI: begin
                ahi   <= sh;
                oe    <= 1'b1;
                acked <= 1'b1;
              end
              PH_ALO: begin
                oe    <= 1'b1;
                acked <= 1'b1;
                if (id_sel) begin
                  idp      <= sh[PAGE_W-1:0];
                  lock_cmd <= abus[LOCK_BIT];
                end else begin
                  ptr <= abus[ADDR_W-1:0];
                end
              end
              PH_WDAT: begin
                oe    <= data_ok;
                acked <= data_ok;
                if (data_ok) begin
                  wrote <= 1'b1;
                  if (id_sel) begin
                    if (lock_cmd) lock_pend <= 1'b1;
                    else begin
                      id_we_q <= 1'b1;
                      id_wa_q <= idp;
                      id_wd_q <= sh;
                      idp     <= idp + 1'b1;
                    end
                  end else begin
                    mem_we_q   <= 1'b1;
                    mem_addr_q <= ptr;
                    mem_wd_q   <= sh;
                    ptr        <= ptr_pinc;
                  end
                end
              end
              default: oe <= 1'b0;
            endcase
          end else if (bcnt == 4'd9) begin
            bcnt <= '0;
            oe   <= 1'b0;
            if (!acked) begin
              ph <= PH_SKIP;
            end else begin
              case (ph)
                PH_DEV: begin
                  if (rw) begin
                    ph  <= PH_RDAT;
                    txb <= rd_byte;
                    oe  <= ~rd_byte[7];
                  end else begin
                    ph <= PH_AHI;
                  end
                end
                PH_AHI: ph <= PH_ALO;
                PH_ALO: ph <= PH_WDAT;
                PH_RDAT: begin
                  txb <= rd_byte;
                  oe  <= ~rd_byte[7];
                end
                default: ph <= ph;
              endcase
            end
          end else if (ph == PH_RDAT) begin
            oe <= ~txb[3'd7 - bcnt[2:0]];
          end
        end
      end
    end
  end

  assign sda_oe    = oe;
  assign mem_addr  = mem_addr_q;
  assign mem_we    = mem_we_q;
  assign mem_wdata = mem_wd_q;

  // R5: while the write cycle runs, a select byte is never acknowledged
  a_r5_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEV && scl_fall && bcnt == 4'd8 && busy) |=> !sda_oe);

  // R4: no array or page write follows a data byte taken with wc high
  a_r4_wc_blocks_array: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(!wc));
  a_r4_wc_blocks_page: assert property (@(posedge clk) disable iff (rst)
    id_we_q |-> $past(!wc));

  // R8: the drive on SDA moves only while the bus clock is low
  a_r8_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;
  localparam int AW = 8;
  localparam int PW = 6;
  localparam int WCYC = 400;
  localparam int H = 8;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic wc = 1'b0;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;

  int checks = 0;
  int errors = 0;

  logic [7:0] bmem [0:(1<<AW)-1];
  logic [7:0] shadow [0:(1<<AW)-1];
  logic [7:0] idsh [0:(1<<PW)-1];

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WCYC), .LOCK_BIT(10)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_en(CE), .wc(wc), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    mem_rdata <= bmem[mem_addr];
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic i2c_start();
    m_low = 1'b0; cyc(H/2);
    m_scl = 1'b1; cyc(H);
    m_low = 1'b1; cyc(H);
    m_scl = 1'b0; cyc(H/2);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; cyc(H/2);
    m_scl = 1'b1; cyc(H);
    m_low = 1'b0; cyc(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; cyc(H);
      m_scl = 1'b1;  cyc(H);
      m_scl = 1'b0;  cyc(H/2);
    end
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; cyc(H);
    m_scl = 1'b1; cyc(H/2);
    ack = ~sda_line; cyc(H/2);
    m_scl = 1'b0; cyc(H/2);
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(H);
      m_scl = 1'b1; cyc(H/2);
      b = {b[6:0], sda_line}; cyc(H/2);
      m_scl = 1'b0; cyc(H/2);
    end
    m_low = give_ack; cyc(H);
    m_scl = 1'b1; cyc(H);
    m_scl = 1'b0; cyc(H/2);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] selb(input bit idpg, input bit rd);
    return {3'b101, idpg, CE, rd};
  endfunction

  task automatic addr_phase(input bit idpg, input logic [15:0] a, output bit ok);
    bit a0, a1, a2;
    i2c_start();
    send(selb(idpg, 1'b0), a0);
    send(a[15:8], a1);
    send(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      bmem[i] = 8'(i ^ 8'h5A);
      shadow[i] = 8'(i ^ 8'h5A);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok, ack, seen_ack, first_ack, last_ack;
    logic [7:0] b;
    logic [AW-1:0] wa;
    cyc(6);
    rst = 1'b0;
    cyc(4);
    chk("R8 reset releases SDA", sda_oe, 0);
    chk("R2 reset no write strobe", mem_we, 0);

    // R1: chip-enable mismatch and wrong type code
    i2c_start();
    send({3'b101, 1'b0, 3'b100, 1'b0}, ack);
    chk("R1 chip-enable mismatch NACK", ack, 0);
    send(8'h00, ack);
    chk("R1 silent after miss", ack, 0);
    i2c_start();
    send({4'b1100, CE, 1'b0}, ack);
    chk("R1 wrong type NACK", ack, 0);
    i2c_stop();

    // R2 byte write, R5 poll during busy
    addr_phase(1'b0, 16'h0013, ok);
    chk("R2 select and address ACK", ok, 1);
    send(8'hA7, ack);
    chk("R2 data ACK", ack, 1);
    shadow[8'h13] = 8'hA7;
    i2c_stop();
    i2c_start();
    send(selb(1'b0, 1'b0), ack);
    chk("R5 select NACK while busy", ack, 0);
    i2c_stop();
    cyc(WCYC + 40);
    i2c_start();
    send(selb(1'b0, 1'b0), ack);
    chk("R5 select ACK after window", ack, 1);
    i2c_stop();
    // R6 random read
    addr_phase(1'b0, 16'h0013, ok);
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    recv(1'b1, b);
    chk("R6 R11 random read", b, 8'hA7);
    recv(1'b0, b);
    chk("R6 next address", b, shadow[8'h14]);
    i2c_stop();

    // R3 page write wrapping inside page 0x40..0x7F
    addr_phase(1'b0, 16'h007A, ok);
    wa = 8'h7A;
    for (int k = 0; k < 10; k++) begin
      send(8'(8'hC0 + k * 7), ack);
      chk("R3 page data ACK", ack, 1);
      shadow[wa] = 8'(8'hC0 + k * 7);
      wa = {wa[7:6], 6'(wa[5:0] + 6'd1)};
    end
    i2c_stop();
    cyc(WCYC + 40);
    addr_phase(1'b0, 16'h0040, ok);
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    for (int k = 0; k < 64; k++) begin
      recv(k != 63, b);
      chk("R3 R7 page readback", b, shadow[8'(8'h40 + k)]);
    end
    i2c_stop();

    // R7 sequential read wrap from top to 0, then R6 current-address read
    addr_phase(1'b0, 16'h00FE, ok);
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    for (int k = 0; k < 4; k++) begin
      recv(k != 3, b);
      chk("R7 wrap read", b, shadow[8'(8'hFE + k)]);
    end
    i2c_stop();
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    recv(1'b0, b);
    chk("R6 current-address read", b, shadow[8'h02]);
    i2c_stop();

    // R4 write control high
    wc = 1'b1;
    addr_phase(1'b0, 16'h0020, ok);
    chk("R4 select and address ACK with wc", ok, 1);
    send(8'h11, ack);
    chk("R4 data NACK with wc", ack, 0);
    i2c_stop();
    i2c_start();
    send(selb(1'b0, 1'b0), ack);
    chk("R4 R5 no busy window", ack, 1);
    i2c_stop();
    addr_phase(1'b0, 16'h0020, ok);
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    recv(1'b0, b);
    chk("R4 byte unchanged, read with wc high", b, shadow[8'h20]);
    i2c_stop();
    wc = 1'b0;

    // R8 Start in the middle of an address byte restarts decoding
    i2c_start();
    send(selb(1'b0, 1'b0), ack);
    send_bits(8'hFF, 3);
    addr_phase(1'b0, 16'h0013, ok);
    chk("R8 restart after partial byte", ok, 1);
    i2c_start();
    send(selb(1'b0, 1'b1), ack);
    recv(1'b0, b);
    chk("R8 read after restart", b, 8'hA7);
    i2c_stop();

    // R9 identification page write with wrap, then read with wrap
    addr_phase(1'b1, 16'h003E, ok);
    chk("R9 page select ACK", ok, 1);
    for (int k = 0; k < 4; k++) begin
      send(8'(8'h30 + k), ack);
      idsh[6'(6'h3E + k)] = 8'(8'h30 + k);
    end
    i2c_stop();
    cyc(WCYC + 40);
    addr_phase(1'b1, 16'h003E, ok);
    i2c_start();
    send(selb(1'b1, 1'b1), ack);
    for (int k = 0; k < 4; k++) begin
      recv(k != 3, b);
      chk("R9 page read wrap", b, idsh[6'(6'h3E + k)]);
    end
    i2c_stop();

    // R10 probe unlocked, lock, probe locked, refused write
    addr_phase(1'b1, 16'h0005, ok);
    send(8'h77, ack);
    chk("R10 probe ACK unlocked", ack, 1);
    idsh[5] = 8'h77;
    i2c_start();
    i2c_stop();
    addr_phase(1'b1, 16'h0400, ok);
    send(8'h00, ack);
    chk("R10 lock command ACK", ack, 1);
    i2c_stop();
    cyc(WCYC + 40);
    addr_phase(1'b1, 16'h0005, ok);
    send(8'hEE, ack);
    chk("R10 probe NACK locked", ack, 0);
    i2c_stop();
    addr_phase(1'b1, 16'h0005, ok);
    i2c_start();
    send(selb(1'b1, 1'b1), ack);
    recv(1'b0, b);
    chk("R10 R9 page unchanged", b, idsh[5]);
    i2c_stop();

    // R5 boundary sweep: poll ACK slot against end of busy window
    seen_ack = 1'b0;
    first_ack = 1'b0;
    last_ack = 1'b0;
    for (int d = 180; d <= 240; d += 4) begin
      wa = 8'(8'h90 + (d - 180) / 4);
      addr_phase(1'b0, {8'h00, wa}, ok);
      send(8'(d), ack);
      shadow[wa] = 8'(d);
      i2c_stop();
      cyc(d);
      i2c_start();
      send(selb(1'b0, 1'b0), ack);
      i2c_stop();
      if (d == 180) first_ack = ack;
      if (d == 240) last_ack = ack;
      chk("R5 poll result monotonic", int'(seen_ack & ~ack), 0);
      seen_ack = seen_ack | ack;
      cyc(WCYC + 40);
      addr_phase(1'b0, {8'h00, wa}, ok);
      i2c_start();
      send(selb(1'b0, 1'b1), ack);
      recv(1'b0, b);
      chk("R5 R2 swept byte stored", b, shadow[wa]);
      i2c_stop();
    end
    chk("R5 earliest poll NACK", first_ack, 0);
    chk("R5 latest poll ACK", last_ack, 1);

    // R10 reset clears lock
    rst = 1'b1; cyc(4); rst = 1'b0; cyc(4);
    addr_phase(1'b1, 16'h0007, ok);
    send(8'h42, ack);
    chk("R10 probe ACK after reset", ack, 1);
    i2c_start();
    i2c_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule